// File: doc/BRIEF.md
# Registered 4-bit ALU datapath

This block is a small clocked arithmetic datapath. On each rising clock edge it loads two 4-bit operands into a pair of source registers and a 4-bit opcode into an instruction register. A combinational unit works on the registered values. It decodes the opcode into one of four operation classes:

- `K_ADD`: a ripple-carry sum.
- `K_AND`: a bitwise AND.
- `K_NOT`: the complement of the first operand.
- `K_NONE`: any unrecognised code.

On the next edge, the unit's result goes into a destination register together with carry, negative, zero and positive status flags.

The decoded class has no stored state of its own. It follows the instruction register: whatever is loaded on one edge selects the behaviour on the next edge.

- `K_NONE` freezes the destination register and all flags.
- Every other class updates them.

A three-bit one-hot indicator, driven from the instruction register, shows which operation is in progress. A single synchronous reset clears every register.

Top module: `alu4_regpath`

## Requirements
- R1: On every rising edge with reset low, `opa_in`, `opb_in` and `opc_in` are loaded into the first source, second source and instruction registers. Their effect shows at the outputs one edge later for the indicator and two edges later for the result.
- R2: Opcode 4'b0001 (add) sets `res_q` to (first source + second source) mod 16. The sum is formed by a four-stage ripple-carry chain.
- R3: `carry_q` takes the carry out of bit 3 on an add. It is cleared by an AND or a NOT.
- R4: Opcode 4'b0101 (AND) sets `res_q` to the bitwise AND of the two source registers.
- R5: Opcode 4'b1001 (NOT) sets `res_q` to the complement of the first source register. The second operand has no effect on the result or on the flags.
- R6: After a valid operation, `neg_q` equals bit 3 of the new result, read as two's complement.
- R7: After a valid operation, `zero_q` is 1 exactly when the new result is 0.
- R8: After a valid operation, `pos_q` is 1 exactly when the result is neither negative nor zero. Exactly one of `neg_q`, `zero_q`, `pos_q` is then set.
- R9: Any opcode other than 4'b0001, 4'b0101 and 4'b1001 leaves `res_q` and all four flags unchanged.
- R10: A rising edge with `rst` high clears all of the following to 0, whatever the inputs are: both source registers, the instruction register, `res_q`, `carry_q`, `neg_q`, `zero_q`, `pos_q` and `op_active`.
- R11: `op_active` encodes the opcode held in the instruction register:
  - bit 0 for add;
  - bit 1 for AND;
  - bit 2 for NOT;
  - all zero for any other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opa_in | input | 4 | First operand |
| opb_in | input | 4 | Second operand |
| opc_in | input | 4 | Opcode |
| res_q | output | 4 | Registered result |
| carry_q | output | 1 | Carry out of the last add |
| neg_q | output | 1 | Result negative |
| zero_q | output | 1 | Result zero |
| pos_q | output | 1 | Result positive |
| op_active | output | 3 | One-hot operation indicator (add, AND, NOT) |

## Verification
An operand/opcode triple driven just after edge c is loaded at edge c+1. The operation indicator is therefore valid from cycle c+1. The result and flags appear after edge c+2.

The driver task stamps each expected item with one of these due cycles before pushing it onto the scoreboard queue. The monitor pops only the items whose due cycle matches the current cycle count, and samples on the falling edge. Consequently, no comparison happens before the pipeline has had time to deliver its value.

Invalid opcodes push a copy of the previously expected state, so that holding is checked in the same slot.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int unsigned OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_ADD  = 2'd1,
        K_AND  = 2'd2,
        K_NOT  = 2'd3
    } op_kind_e;

    function automatic op_kind_e decode_op(input logic [OPC_W-1:0] opc);
        op_kind_e k;
        unique case (opc)
            OPC_ADD: k = K_ADD;
            OPC_AND: k = K_AND;
            OPC_NOT: k = K_NOT;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/alu4_ripple_add.sv
module alu4_ripple_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] cy;

    assign cy[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic half;
        assign half      = a[i] ^ b[i];
        assign sum[i]    = half ^ cy[i];
        assign cy[i+1]   = (a[i] & b[i]) | (cy[i] & half);
    end

    assign cout = cy[W];

endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  op_kind_e     kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         cy,
    output logic         valid
);

    logic [W-1:0] add_sum;
    logic         add_cout;

    alu4_ripple_add #(.W(W)) adder_i (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .sum  (add_sum),
        .cout (add_cout)
    );

    always_comb begin
        y     = '0;
        cy    = 1'b0;
        valid = 1'b0;
        unique case (kind)
            K_ADD: begin
                y     = add_sum;
                cy    = add_cout;
                valid = 1'b1;
            end
            K_AND: begin
                y     = a & b;
                valid = 1'b1;
            end
            K_NOT: begin
                y     = ~a;
                valid = 1'b1;
            end
            K_NONE: begin
                valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu4_flags.sv
module alu4_flags #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] y,
    output logic         n,
    output logic         z,
    output logic         p
);

    always_comb begin
        n = y[W-1];
        z = (y == '0);
        p = !n && !z;
    end

endmodule

// File: rtl/alu4_regpath.sv
module alu4_regpath
    import alu4_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         opa_in,
    input  logic [W-1:0]         opb_in,
    input  logic [OPC_W-1:0]     opc_in,
    output logic [W-1:0]         res_q,
    output logic                 carry_q,
    output logic                 neg_q,
    output logic                 zero_q,
    output logic                 pos_q,
    output logic [2:0]           op_active
);

    logic [W-1:0]     sr1_q;
    logic [W-1:0]     sr2_q;
    logic [OPC_W-1:0] ir_q;
    op_kind_e         ir_kind;

    logic [W-1:0]     alu_y;
    logic             alu_cy;
    logic             alu_valid;
    logic             f_n, f_z, f_p;

    // Stage 1: operand and instruction capture
    always_ff @(posedge clk) begin
        if (rst) begin
            sr1_q <= '0;
            sr2_q <= '0;
            ir_q  <= '0;
        end else begin
            sr1_q <= opa_in;
            sr2_q <= opb_in;
            ir_q  <= opc_in;
        end
    end

    assign ir_kind = decode_op(ir_q);

    alu4_core #(.W(W)) core_i (
        .kind  (ir_kind),
        .a     (sr1_q),
        .b     (sr2_q),
        .y     (alu_y),
        .cy    (alu_cy),
        .valid (alu_valid)
    );

    alu4_flags #(.W(W)) flags_i (
        .y (alu_y),
        .n (f_n),
        .z (f_z),
        .p (f_p)
    );

    // Stage 2: destination and status capture
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            carry_q <= 1'b0;
            neg_q   <= 1'b0;
            zero_q  <= 1'b0;
            pos_q   <= 1'b0;
        end else if (alu_valid) begin
            res_q   <= alu_y;
            carry_q <= alu_cy;
            neg_q   <= f_n;
            zero_q  <= f_z;
            pos_q   <= f_p;
        end
    end

    // Operation indicator from the instruction register
    always_comb begin
        op_active = 3'b000;
        unique case (ir_kind)
            K_ADD:  op_active[0] = 1'b1;
            K_AND:  op_active[1] = 1'b1;
            K_NOT:  op_active[2] = 1'b1;
            K_NONE: op_active    = 3'b000;
        endcase
    end

    // R2 R3
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_kind == K_ADD) |=>
            ({carry_q, res_q} == ({1'b0, $past(sr1_q)} + {1'b0, $past(sr2_q)})));

    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_kind == K_AND || ir_kind == K_NOT) |=> !carry_q);

    // R4
    and_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_kind == K_AND) |=> (res_q == ($past(sr1_q) & $past(sr2_q))));

    // R5
    not_result_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_kind == K_NOT) |=> (res_q == ~$past(sr1_q)));

    // R6
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alu_valid |=> (neg_q == res_q[W-1]));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alu_valid |=> (zero_q == (res_q == '0)));

    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alu_valid |=> ($countones({neg_q, zero_q, pos_q}) == 1));

    // R9
    hold_invalid_chk: assert property (@(posedge clk) disable iff (rst)
        (ir_kind == K_NONE) |=>
            ($stable(res_q) && $stable({carry_q, neg_q, zero_q, pos_q})));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !carry_q && !neg_q && !zero_q && !pos_q
                 && op_active == 3'b000));

    // R11
    indicator_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_active));

endmodule

// File: tb/alu4_regpath_tb.sv
module alu4_regpath_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opa = 4'h0;
    logic [3:0] opb = 4'h0;
    logic [3:0] opc = 4'h0;
    logic [3:0] res_q;
    logic       carry_q, neg_q, zero_q, pos_q;
    logic [2:0] op_active;

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    alu4_regpath dut_i (
        .clk       (clk),
        .rst       (rst),
        .opa_in    (opa),
        .opb_in    (opb),
        .opc_in    (opc),
        .res_q     (res_q),
        .carry_q   (carry_q),
        .neg_q     (neg_q),
        .zero_q    (zero_q),
        .pos_q     (pos_q),
        .op_active (op_active)
    );

    typedef struct {
        int         due;
        bit         is_res;
        logic [3:0] res;
        logic       c, n, z, p;
        logic [2:0] oh;
        string      tag;
    } exp_t;

    exp_t q[$];

    logic [3:0] m_res = 4'h0;
    logic       m_c = 1'b0, m_n = 1'b0, m_z = 1'b0, m_p = 1'b0;

    task automatic drive(input logic [3:0] a, input logic [3:0] b,
                         input logic [3:0] op, input string tag);
        exp_t e;
        logic [4:0] s;
        bit v;
        logic [2:0] oh;
        @(posedge clk);
        #1;
        opa = a; opb = b; opc = op;
        v = 1'b1;
        oh = 3'b000;
        case (op)
            4'b0001: begin
                s = {1'b0, a} + {1'b0, b};
                m_res = s[3:0]; m_c = s[4]; oh = 3'b001;
            end
            4'b0101: begin m_res = a & b; m_c = 1'b0; oh = 3'b010; end
            4'b1001: begin m_res = ~a;    m_c = 1'b0; oh = 3'b100; end
            default: v = 1'b0;
        endcase
        if (v) begin
            m_n = m_res[3];
            m_z = (m_res == 4'h0);
            m_p = !m_n && !m_z;
        end
        e.due = cyc + 1; e.is_res = 1'b0; e.oh = oh;
        e.res = 4'h0; e.c = 1'b0; e.n = 1'b0; e.z = 1'b0; e.p = 1'b0;
        e.tag = "R1 R11";
        q.push_back(e);
        e.due = cyc + 2; e.is_res = 1'b1;
        e.res = m_res; e.c = m_c; e.n = m_n; e.z = m_z; e.p = m_p;
        e.tag = tag;
        q.push_back(e);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.is_res) begin
                if ({res_q, carry_q, neg_q, zero_q, pos_q} !==
                    {e.res, e.c, e.n, e.z, e.p}) begin
                    errors++;
                    $display("FAIL %s: res/c/n/z/p got %h/%b%b%b%b expected %h/%b%b%b%b",
                             e.tag, res_q, carry_q, neg_q, zero_q, pos_q,
                             e.res, e.c, e.n, e.z, e.p);
                end
            end else begin
                if (op_active !== e.oh) begin
                    errors++;
                    $display("FAIL %s: op_active got %b expected %b",
                             e.tag, op_active, e.oh);
                end
            end
        end
    end

    task automatic check_reset_state;
        @(negedge clk);
        checks++;
        if ({res_q, carry_q, neg_q, zero_q, pos_q, op_active} !== 11'b0) begin
            errors++;
            $display("FAIL R10: res/c/n/z/p/oh got %h/%b%b%b%b/%b expected 0/0000/000",
                     res_q, carry_q, neg_q, zero_q, pos_q, op_active);
        end
    endtask

    initial begin
        // R10: reset wins over a valid add on the inputs
        opa = 4'h7; opb = 4'h3; opc = 4'b0001;
        repeat (2) @(posedge clk);
        check_reset_state();
        @(posedge clk);
        #1;
        rst = 1'b0; opa = 4'h0; opb = 4'h0; opc = 4'h0;

        drive(4'h2, 4'h3, 4'b0001, "R1 R2 R8");          // 5 positive
        drive(4'h7, 4'h1, 4'b0001, "R2 R6");             // 8 negative, no carry
        drive(4'hF, 4'h1, 4'b0001, "R2 R3 R7");          // 0, carry
        drive(4'h8, 4'h8, 4'b0001, "R3 R7");             // 0, carry
        drive(4'h9, 4'h9, 4'b0001, "R2 R3 R8");          // 2, carry
        drive(4'h5, 4'hA, 4'b0101, "R4 R3 R7");          // AND clears carry, zero
        drive(4'hF, 4'hC, 4'b0101, "R4 R6");             // C negative
        drive(4'h6, 4'h3, 4'b0101, "R4 R8");             // 2 positive
        drive(4'h0, 4'h5, 4'b1001, "R5 R6");             // F negative
        drive(4'hF, 4'h0, 4'b1001, "R5 R7");             // 0 zero
        drive(4'h8, 4'hF, 4'b1001, "R5 R8");             // 7 positive
        drive(4'h8, 4'h0, 4'b1001, "R5");                // same, other b
        drive(4'hC, 4'h7, 4'b0001, "R3");                // 3 with carry
        drive(4'h1, 4'h1, 4'b0000, "R9");                // hold carry and 3
        drive(4'hE, 4'hE, 4'b1111, "R9");
        drive(4'h3, 4'h4, 4'b0101, "R9 R1");             // AND after hold -> 0
        drive(4'h2, 4'h2, 4'b0100, "R9");
        drive(4'h4, 4'h4, 4'b0001, "R2 R6");             // back-to-back
        drive(4'h1, 4'h2, 4'b1001, "R5 R6");
        drive(4'h0, 4'h0, 4'b0000, "R9");

        while (q.size() != 0) @(posedge clk);

        // R10: mid-run reset
        @(posedge clk);
        #1;
        rst = 1'b1;
        @(posedge clk);
        check_reset_state();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule